// File: doc/BRIEF.md
# Address translation buffer with access-right checking

This block is a small fully associative cache of page translations. A lookup presents a virtual address, the kind of access (read, write or instruction fetch) and whether the requester runs in user mode. In the same cycle the block answers with one of four outcomes: a translated physical address, a miss, a not-present page fault or a protection fault. Pages are 4 KB, so the twelve low address bits pass straight through, and the remaining bits form the virtual page number that is compared against every stored tag at once.

On a miss the block raises a refill request. An external table walker answers through the refill port with the page number, access rights and status bits, and the block writes them into a free slot or into the least recently used one. A write that the entry permits marks the entry dirty. The dirty state is reported with every hit. When software changes a mapping, it names the virtual page on the invalidate port, and the next access to that page misses and reloads the new bits.

Top module: `tlb_prot`

## Requirements
- R1: On a hit `paddr_o` equals the stored physical page number above `vaddr_i[11:0]`, in the same cycle as the lookup. On any other outcome `paddr_o` is zero.
- R2: The buffer holds 8 entries, and any of them can hold any page. A lookup matches an occupied entry whose tag equals `vaddr_i[31:12]`.
- R3: A request that matches no occupied entry gives `fault_o` = 1, raises `refill_req_o` and keeps `hit_o` low.
- R4: A request whose matching entry is marked not present gives `fault_o` = 2. This outcome takes priority over a permission failure.
- R5: `refill_prot_i` bit 0 allows read, bit 1 allows write, bit 2 allows fetch, and bit 3 makes the page supervisor-only. `acc_i` is 0 for read, 1 for write, 2 for fetch, and 3 is always denied. An access without its right, or a user-mode access (`user_i`=1) to a supervisor-only page, gives `fault_o` = 3.
- R6: Each request reports exactly one outcome. A translation gives `hit_o`=1 and `fault_o`=0. With no request, `hit_o`, `refill_req_o`, `fault_o` and `paddr_o` are all zero.
- R7: A write that hits sets the entry's dirty bit from the next cycle on. A write that faults leaves the bit unchanged. `dirty_o` shows the stored bit during a hit and is zero otherwise.
- R8: A refill writes a new entry. A lookup of that page in the next cycle hits with the new data. A refill of a page that is already held overwrites that same entry.
- R9: A refill of a new page goes to the lowest-index unoccupied entry. If every entry is occupied, it goes to the lowest-index entry whose use bit is clear.
- R10: A refill, or a request that matches an entry (any outcome except a miss), sets that entry's use bit. If this leaves every use bit set, all other use bits are cleared. An invalidate clears the use bit of the entry it removes.
- R11: An invalidate removes the entry holding the named page, so the next request for that page misses. An invalidate of a page that is not held changes nothing.
- R12: After reset no entry is occupied, and every request misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| user_i | input | 1 | Requester runs in user mode |
| hit_o | output | 1 | Translation succeeded |
| fault_o | output | 2 | 0 none, 1 miss, 2 not present, 3 protection |
| refill_req_o | output | 1 | Miss; a refill is wanted |
| paddr_o | output | 32 | Physical address on a hit |
| dirty_o | output | 1 | Dirty bit of the hit entry |
| refill_i | input | 1 | Write a refilled entry |
| refill_vpn_i | input | 20 | Virtual page of the refill |
| refill_ppn_i | input | 20 | Physical page of the refill |
| refill_prot_i | input | 4 | Rights: read, write, fetch, supervisor-only |
| refill_present_i | input | 1 | Page is present |
| refill_dirty_i | input | 1 | Initial dirty bit |
| inval_i | input | 1 | Invalidate request |
| inval_vpn_i | input | 20 | Virtual page to invalidate |

## Verification
The bench aims at the outcome ordering. A page that is not present and also lacks the right must report a page fault; a design with the checks swapped reports a protection fault instead. It writes to read-only pages and then confirms that the dirty bit stays clear, which catches a design that marks the entry before it checks the rights. It fills every slot and then refills, so that the victim order and the clearing of the use bits decide which page disappears. An off-by-one victim or stale use bits then show up as a wrong miss on a later lookup. It also overwrites a page that is already held and invalidates pages that are not held, which would expose duplicate tags or an entry that an invalidate cleared when it should not have.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_MISS = 2'd1,
    RES_PAGE = 2'd2,
    RES_PROT = 2'd3
  } res_e;

  typedef struct packed {
    logic sup;
    logic ex;
    logic wr;
    logic rd;
  } prot_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter  int N     = 8,
  parameter  int TAG_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]        key_i,
  output logic                    hit_o,
  output logic [N-1:0]            oh_o,
  output logic [IDX_W-1:0]        idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign oh_o[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  assign hit_o = |oh_o;

  // tags are unique, so OR-encoding the one-hot is exact
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (oh_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm (
  input  logic [3:0] prot_i,
  input  logic [1:0] acc_i,
  input  logic       user_i,
  output logic       allow_o
);
  import tlb_pkg::*;

  prot_t p;
  logic  right;

  assign p = prot_t'(prot_i);

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  right = p.rd;
      ACC_WRITE: right = p.wr;
      ACC_FETCH: right = p.ex;
      default:   right = 1'b0;
    endcase
  end

  assign allow_o = right && !(user_i && p.sup);
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter  int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     occ_i,
  input  logic [N-1:0]     use_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [N-1:0]     clr_i,
  output logic [IDX_W-1:0] victim_o,
  output logic [N-1:0]     use_d_o
);
  logic [N-1:0] touch_oh;
  logic [N-1:0] use_set;

  always_comb begin
    victim_o = '0;
    if (&occ_i) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (!use_i[i]) victim_o = IDX_W'(i);
      end
    end else begin
      for (int i = N - 1; i >= 0; i--) begin
        if (!occ_i[i]) victim_o = IDX_W'(i);
      end
    end
  end

  assign touch_oh = touch_i ? (N'(1) << touch_idx_i) : '0;

  always_comb begin
    use_set = use_i | touch_oh;
    if (touch_i && (&use_set)) use_set = touch_oh;
    use_d_o = use_set & ~clr_i;
  end
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot #(
  parameter  int VA_W    = 32,
  parameter  int PA_W    = 32,
  parameter  int OFFS_W  = 12,
  parameter  int ENTRIES = 8,
  localparam int VPN_W   = VA_W - OFFS_W,
  localparam int PPN_W   = PA_W - OFFS_W,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  output logic             hit_o,
  output logic [1:0]       fault_o,
  output logic             refill_req_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             dirty_o,
  input  logic             refill_i,
  input  logic [VPN_W-1:0] refill_vpn_i,
  input  logic [PPN_W-1:0] refill_ppn_i,
  input  logic [3:0]       refill_prot_i,
  input  logic             refill_present_i,
  input  logic             refill_dirty_i,
  input  logic             inval_i,
  input  logic [VPN_W-1:0] inval_vpn_i
);
  import tlb_pkg::*;

  logic [ENTRIES-1:0]            occ_q, use_q, dirty_q, pres_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][3:0]       prot_q;

  logic [VPN_W-1:0]   l_vpn;
  logic               l_hit, r_hit, i_hit;
  logic [ENTRIES-1:0] l_oh, r_oh, i_oh;
  logic [IDX_W-1:0]   l_idx, r_idx_m, i_idx;
  logic [IDX_W-1:0]   victim, r_idx;
  logic               allow;
  res_e               res;
  logic               touch;
  logic [IDX_W-1:0]   touch_idx;
  logic [ENTRIES-1:0] use_d;
  logic               wr_ok;

  assign l_vpn = vaddr_i[VA_W-1:OFFS_W];

  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
    .valid_i(occ_q), .tags_i(vpn_q), .key_i(l_vpn),
    .hit_o(l_hit), .oh_o(l_oh), .idx_o(l_idx)
  );

  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_rf_match (
    .valid_i(occ_q), .tags_i(vpn_q), .key_i(refill_vpn_i),
    .hit_o(r_hit), .oh_o(r_oh), .idx_o(r_idx_m)
  );

  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_iv_match (
    .valid_i(occ_q), .tags_i(vpn_q), .key_i(inval_vpn_i),
    .hit_o(i_hit), .oh_o(i_oh), .idx_o(i_idx)
  );

  tlb_perm u_perm (
    .prot_i(prot_q[l_idx]), .acc_i(acc_i), .user_i(user_i), .allow_o(allow)
  );

  // priority: miss, not present, protection
  always_comb begin
    if (!l_hit)              res = RES_MISS;
    else if (!pres_q[l_idx]) res = RES_PAGE;
    else if (!allow)         res = RES_PROT;
    else                     res = RES_OK;
  end

  assign hit_o        = req_valid_i && (res == RES_OK);
  assign refill_req_o = req_valid_i && (res == RES_MISS);
  assign fault_o      = req_valid_i ? res : RES_OK;
  assign paddr_o      = hit_o ? {ppn_q[l_idx], vaddr_i[OFFS_W-1:0]} : '0;
  assign dirty_o      = hit_o && dirty_q[l_idx];
  assign wr_ok        = hit_o && (acc_e'(acc_i) == ACC_WRITE);

  // an already-held page is overwritten in place to keep tags unique
  assign r_idx     = r_hit ? r_idx_m : victim;
  assign touch     = refill_i || (req_valid_i && l_hit);
  assign touch_idx = refill_i ? r_idx : l_idx;

  tlb_repl #(.N(ENTRIES)) u_repl (
    .occ_i(occ_q), .use_i(use_q), .touch_i(touch), .touch_idx_i(touch_idx),
    .clr_i(inval_i ? i_oh : '0), .victim_o(victim), .use_d_o(use_d)
  );

  // ordering within a cycle: lookup update, then refill, then invalidate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q   <= '0;
      use_q   <= '0;
      dirty_q <= '0;
    end else begin
      use_q <= use_d;
      if (wr_ok) dirty_q[l_idx] <= 1'b1;
      if (refill_i) begin
        occ_q[r_idx]   <= 1'b1;
        dirty_q[r_idx] <= refill_dirty_i;
      end
      if (inval_i && i_hit) occ_q[i_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (refill_i) begin
      vpn_q[r_idx]  <= refill_vpn_i;
      ppn_q[r_idx]  <= refill_ppn_i;
      prot_q[r_idx] <= refill_prot_i;
      pres_q[r_idx] <= refill_present_i;
    end
  end
endmodule

// File: rtl/tlb_prot_chk.sv
module tlb_prot_chk #(
  parameter  int VA_W   = 32,
  parameter  int PA_W   = 32,
  parameter  int OFFS_W = 12,
  localparam int VPN_W  = VA_W - OFFS_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  vaddr_i,
  input logic [1:0]       acc_i,
  input logic             hit_o,
  input logic [1:0]       fault_o,
  input logic             refill_req_o,
  input logic [PA_W-1:0]  paddr_o,
  input logic             dirty_o,
  input logic             refill_i,
  input logic [VPN_W-1:0] refill_vpn_i,
  input logic             inval_i,
  input logic [VPN_W-1:0] inval_vpn_i
);
  a_r1_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o[OFFS_W-1:0] == vaddr_i[OFFS_W-1:0]);

  a_r1_no_addr_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> paddr_o == '0);

  a_r6_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (hit_o == (fault_o == 2'd0)) && (refill_req_o == (fault_o == 2'd1)));

  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !hit_o && !refill_req_o && fault_o == 2'd0 && !dirty_o);

  a_r8_refill_then_found: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_i && !inval_i) |=>
      !(req_valid_i && vaddr_i[VA_W-1:OFFS_W] == $past(refill_vpn_i) && refill_req_o));

  a_r11_inval_then_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_i && !refill_i) |=>
      !(req_valid_i && vaddr_i[VA_W-1:OFFS_W] == $past(inval_vpn_i) && !refill_req_o));

  a_r7_dirty_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && acc_i == 2'd1 && !refill_i && !inval_i) |=>
      !(hit_o && vaddr_i[VA_W-1:OFFS_W] == $past(vaddr_i[VA_W-1:OFFS_W]) && !dirty_o));
endmodule

bind tlb_prot tlb_prot_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .vaddr_i(vaddr_i),
  .acc_i(acc_i), .hit_o(hit_o), .fault_o(fault_o), .refill_req_o(refill_req_o),
  .paddr_o(paddr_o), .dirty_o(dirty_o), .refill_i(refill_i),
  .refill_vpn_i(refill_vpn_i), .inval_i(inval_i), .inval_vpn_i(inval_vpn_i)
);

// File: tb/tlb_prot_tb_top.sv
module tlb_prot_tb_top;
  localparam int N = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [1:0]  acc_i = '0;
  logic        user_i = 1'b0;
  logic        hit_o, refill_req_o, dirty_o;
  logic [1:0]  fault_o;
  logic [31:0] paddr_o;
  logic        refill_i = 1'b0;
  logic [19:0] refill_vpn_i = '0, refill_ppn_i = '0, inval_vpn_i = '0;
  logic [3:0]  refill_prot_i = '0;
  logic        refill_present_i = 1'b0, refill_dirty_i = 1'b0, inval_i = 1'b0;

  tlb_prot dut_i (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0;
  int n_err = 0;

  logic [N-1:0]       m_occ = '0, m_use = '0, m_dirty = '0, m_pres = '0;
  logic [19:0]        m_vpn [N];
  logic [19:0]        m_ppn [N];
  logic [3:0]         m_prot [N];

  function automatic int find(logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_occ[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void touch(int k);
    logic [N-1:0] oh, nu;
    oh = N'(1) << k;
    nu = m_use | oh;
    if (&nu) nu = oh;
    m_use = nu;
  endfunction

  function automatic logic [36:0] expect_lk(logic [19:0] vpn, logic [11:0] off,
                                            logic [1:0] acc, logic user);
    int k;
    logic ok;
    k = find(vpn);
    if (k < 0) return {1'b0, 1'b1, 2'd1, 1'b0, 32'd0};
    if (!m_pres[k]) return {1'b0, 1'b0, 2'd2, 1'b0, 32'd0};
    case (acc)
      2'd0: ok = m_prot[k][0];
      2'd1: ok = m_prot[k][1];
      2'd2: ok = m_prot[k][2];
      default: ok = 1'b0;
    endcase
    if (user && m_prot[k][3]) ok = 1'b0;
    if (!ok) return {1'b0, 1'b0, 2'd3, 1'b0, 32'd0};
    return {1'b1, 1'b0, 2'd0, m_dirty[k], m_ppn[k], off};
  endfunction

  task automatic check(input bit cond, input string req, input logic [36:0] act,
                       input logic [36:0] exp);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid_i = 1'b0; refill_i = 1'b0; inval_i = 1'b0;
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [1:0] acc, input logic user, input string req);
    logic [36:0] exp, act;
    int k;
    @(negedge clk_i);
    idle_inputs();
    req_valid_i = 1'b1; vaddr_i = {vpn, off}; acc_i = acc; user_i = user;
    #5;
    exp = expect_lk(vpn, off, acc, user);
    act = {hit_o, refill_req_o, fault_o, dirty_o, paddr_o};
    check(act == exp, req, act, exp);
    @(posedge clk_i);
    k = find(vpn);
    if (k >= 0) begin
      touch(k);
      if (exp[36] && acc == 2'd1) m_dirty[k] = 1'b1;
    end
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [3:0] prot, input logic pres, input logic dirty);
    int k;
    @(negedge clk_i);
    idle_inputs();
    refill_i = 1'b1; refill_vpn_i = vpn; refill_ppn_i = ppn;
    refill_prot_i = prot; refill_present_i = pres; refill_dirty_i = dirty;
    @(posedge clk_i);
    k = find(vpn);
    if (k < 0) begin
      k = 0;
      if (&m_occ) begin
        for (int i = N - 1; i >= 0; i--) if (!m_use[i]) k = i;
      end else begin
        for (int i = N - 1; i >= 0; i--) if (!m_occ[i]) k = i;
      end
    end
    m_occ[k] = 1'b1; m_vpn[k] = vpn; m_ppn[k] = ppn; m_prot[k] = prot;
    m_pres[k] = pres; m_dirty[k] = dirty;
    touch(k);
  endtask

  task automatic inval(input logic [19:0] vpn);
    int k;
    @(negedge clk_i);
    idle_inputs();
    inval_i = 1'b1; inval_vpn_i = vpn;
    @(posedge clk_i);
    k = find(vpn);
    if (k >= 0) begin
      m_occ[k] = 1'b0;
      m_use[k] = 1'b0;
    end
  endtask

  task automatic idle_check();
    logic [36:0] act;
    @(negedge clk_i);
    idle_inputs();
    vaddr_i = 32'h0001_0123;
    #5;
    act = {hit_o, refill_req_o, fault_o, dirty_o, paddr_o};
    check(act == '0, "R6 idle", act, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240917);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    lookup(20'h00010, 12'h123, 2'd0, 1'b0, "R12 empty after reset");
    lookup(20'h00000, 12'h000, 2'd2, 1'b1, "R3 miss");
    idle_check();

    refill(20'h00010, 20'hABCDE, 4'b0001, 1'b1, 1'b0);
    lookup(20'h00010, 12'h456, 2'd0, 1'b1, "R1 R8 read hit");
    lookup(20'h00010, 12'h456, 2'd1, 1'b0, "R5 write to read-only");
    lookup(20'h00010, 12'h456, 2'd2, 1'b0, "R5 fetch without right");
    lookup(20'h00010, 12'hFFF, 2'd0, 1'b0, "R7 faulted write left clean");
    lookup(20'h00010, 12'h001, 2'd3, 1'b0, "R5 reserved kind denied");

    refill(20'h00020, 20'h11111, 4'b1111, 1'b1, 1'b0);
    lookup(20'h00020, 12'h010, 2'd0, 1'b1, "R5 user on supervisor page");
    lookup(20'h00020, 12'h010, 2'd2, 1'b0, "R5 supervisor fetch");

    refill(20'h00030, 20'h22222, 4'b0000, 1'b0, 1'b0);
    lookup(20'h00030, 12'h000, 2'd1, 1'b1, "R4 not present beats protection");
    lookup(20'h00030, 12'h000, 2'd0, 1'b0, "R4 page fault");

    refill(20'h00040, 20'h33333, 4'b0011, 1'b1, 1'b0);
    lookup(20'h00040, 12'h044, 2'd1, 1'b0, "R7 first write clean");
    lookup(20'h00040, 12'h044, 2'd1, 1'b0, "R7 second write dirty");
    lookup(20'h00040, 12'h044, 2'd0, 1'b1, "R7 read sees dirty");

    refill(20'h00010, 20'h5A5A5, 4'b0111, 1'b1, 1'b1);
    lookup(20'h00010, 12'h321, 2'd1, 1'b1, "R8 overwrite held page");

    inval(20'h00020);
    lookup(20'h00020, 12'h010, 2'd0, 1'b0, "R11 invalidated page misses");
    inval(20'hFFFFF);
    lookup(20'h00010, 12'h321, 2'd0, 1'b0, "R11 absent invalidate harmless");
    lookup(20'h00040, 12'h044, 2'd0, 1'b0, "R11 absent invalidate harmless");

    for (int i = 0; i < 10; i++)
      refill(20'h00100 + 20'(i), 20'h40000 + 20'(i), 4'b0111, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++)
      lookup(20'h00100 + 20'(i), 12'h0A0, 2'd0, 1'b0, "R9 R10 replacement");
    lookup(20'h00010, 12'h000, 2'd0, 1'b0, "R9 evicted page");
    lookup(20'h00040, 12'h000, 2'd0, 1'b0, "R9 evicted page");
    idle_check();

    for (int it = 0; it < 600; it++) begin
      int unsigned op;
      logic [19:0] v;
      op = $urandom_range(0, 9);
      v  = 20'h00200 + 20'($urandom_range(0, 11));
      if (op < 5)
        lookup(v, 12'($urandom), 2'($urandom), 1'($urandom), "R2 R6 R10 random lookup");
      else if (op < 8)
        refill(v, 20'($urandom), 4'($urandom), ($urandom_range(0, 4) != 0), 1'($urandom));
      else
        inval(v);
    end

    @(negedge clk_i);
    idle_inputs();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule